// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a register-mapped general-purpose I/O controller. It serves a parameterised number of pins, 95 by default. Pins are grouped into 32-wide banks for three bitmapped words: a firmware ownership mask, latched interrupt status and interrupt enable. Each pin also has two private 32-bit configuration words. These set its output level, direction, function select, trigger mode, weak-pull code and input-sense gate, and they return the pin's sampled input level.

Every pin input passes through a two-stage synchroniser. When sensing is enabled, it updates a sampled level. An edge or level detector watches that level in one of four trigger modes and sets a sticky status bit. Software clears a status bit by writing a one to it. A single interrupt line is raised while any pin has both its status and its enable bit set.

The register port is a plain single-cycle strobe interface with no back-pressure: every read or write strobe is accepted on the clock edge where it is sampled. Read data is registered and is valid on the cycle after the read strobe. It then holds until the next read.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, each first configuration word reads 0x0000_0004 (input, function select 0) and each second word reads 0x0000_0004 (sensing off). All status and enable bits are 0, the interrupt line is low, and the ownership words hold the OWN_INIT parameter.
- R2: Bank words lie at base+4×(pin/32), with the pin in bit pin%32. The bases are 0x00 for ownership, 0x80 for status and 0x90 for enable. Pin n has its first configuration word at 0x100+8n and its second at 0x104+8n. Read data is valid the cycle after the read strobe.
- R3: In the first word, bit 31 is the output level, bit 2 the direction (1 = input) and bits 1:0 the function select (1 = GPIO). pin_oe is high only with bit 2 = 0 and bits 1:0 = 1. pin_out carries bit 31.
- R4: First-word bit 30 is read-only and shows the synchronised pin level. While second-word bit 2 (sense off) is 1, it holds its value.
- R5: With first-word bit 4 (level mode) = 0 and bit 3 (invert) = 0, a rising pin edge sets the pin's status bit. A falling edge does not.
- R6: With bit 4 = 0 and bit 3 = 1, a falling edge sets status. A rising edge does not.
- R7: With bit 4 = 1 and bit 3 = 0, a low level sets status on every clock, so a clear does not take effect while the pin stays low.
- R8: With bit 4 = 1 and bit 3 = 1, a high level sets status on every clock.
- R9: Writing a one to a status bit clears it. Writing zero leaves it unchanged, and writing all ones clears the bank.
- R10: irq is the OR over all pins of (status AND enable). Status latches even with enable clear.
- R11: Unmapped addresses, and bank or configuration slots past the last pin, read 0. Writes to them change nothing.
- R12: While sensing is off, no trigger mode sets status.
- R13: Second-word bits 1:0 (weak-pull code) are stored and read back. Other unlisted bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address (word aligned) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Driven output levels |
| pin_oe | output | NUM_PINS | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default 95 pins and a 12-bit address, so the third bank is partial: bit 31 of each bank word at offset 8 has no pin behind it. It also sets OWN_INIT to an irregular pattern, so each ownership word carries a distinguishable reset value. This exposes the unused slot past the last pin in both the bank words and the configuration window, and it lets the bench exercise every trigger mode on pins in all three banks.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BANK_W    = 32;
  // Bank windows are 16-byte aligned; up to four banks fit in each window.
  localparam int unsigned OWN_BASE  = 'h000;
  localparam int unsigned STAT_BASE = 'h080;
  localparam int unsigned ENA_BASE  = 'h090;
  localparam int unsigned CFG_BASE  = 'h100;

  localparam logic [1:0] USE_GPIO = 2'd1;

  // {level_mode, invert}
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic       out_lvl;
    logic       lvl_mode;
    logic       invert;
    logic       dir_in;
    logic [1:0] use_sel;
  } cfg_main_t;

  typedef struct packed {
    logic       no_sense;
    logic [1:0] pull;
  } cfg_aux_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_s,
  input  logic              wr_main,
  input  logic              wr_aux,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr,
  output logic [WORD_W-1:0] main_word,
  output logic [WORD_W-1:0] aux_word,
  output logic              status,
  output logic              pin_out,
  output logic              pin_oe
);
  cfg_main_t  cm;
  cfg_aux_t   ca;
  logic       in_lvl, in_prev;
  logic       hit, evt;
  trig_mode_e mode;
  logic       unused_wbits;

  assign unused_wbits = ^wdata[30:5];
  assign mode = trig_mode_e'({cm.lvl_mode, cm.invert});

  always_comb begin
    unique case (mode)
      TRIG_RISE: hit = in_lvl & ~in_prev;
      TRIG_FALL: hit = ~in_lvl & in_prev;
      TRIG_LOW:  hit = ~in_lvl;
      TRIG_HIGH: hit = in_lvl;
      default:   hit = 1'b0;
    endcase
    evt = hit & ~ca.no_sense;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm      <= '{out_lvl: 1'b0, lvl_mode: 1'b0, invert: 1'b0, dir_in: 1'b1, use_sel: 2'd0};
      ca      <= '{no_sense: 1'b1, pull: 2'd0};
      in_lvl  <= 1'b0;
      in_prev <= 1'b0;
      status  <= 1'b0;
    end else begin
      if (wr_main) cm <= '{out_lvl: wdata[31], lvl_mode: wdata[4], invert: wdata[3],
                           dir_in: wdata[2], use_sel: wdata[1:0]};
      if (wr_aux)  ca <= '{no_sense: wdata[2], pull: wdata[1:0]};
      if (!ca.no_sense) in_lvl <= pin_s;
      in_prev <= in_lvl;
      status  <= (status & ~clr) | evt;
    end
  end

  assign main_word = {cm.out_lvl, in_lvl, 25'd0, cm.lvl_mode, cm.invert, cm.dir_in, cm.use_sel};
  assign aux_word  = {29'd0, ca.no_sense, ca.pull};
  assign pin_oe    = ~cm.dir_in & (cm.use_sel == USE_GPIO);
  assign pin_out   = cm.out_lvl;

  assert_evt_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status);
  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status);
  assert_level_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ca.no_sense |=> $stable(in_lvl));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned          NUM_PINS = 95,
  parameter int unsigned          ADDR_W   = 12,
  parameter logic [NUM_PINS-1:0]  OWN_INIT = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned PAD_W     = NUM_BANKS * BANK_W;
  localparam int unsigned BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned PIDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int unsigned WIN_SPAN  = NUM_BANKS * 4;
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OWN_BASE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_BASE);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_BASE);

  function automatic logic [PAD_W-1:0] pin_mask();
    logic [PAD_W-1:0] m;
    for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
    return m;
  endfunction
  localparam logic [PAD_W-1:0] VALID_MASK = pin_mask();

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] d;
    d = a - base;
    return (a >= base) && (d < ADDR_W'(WIN_SPAN));
  endfunction

  // ---------------- address decode ----------------
  logic              aligned, own_hit, stat_hit, ena_hit, cfg_hit, any_hit;
  logic [BIDX_W-1:0] bank_idx;
  logic [ADDR_W-1:0] cfg_off;
  logic [PIDX_W-1:0] pin_idx;
  logic              cfg_aux_sel;
  logic              unused_abits;

  assign aligned     = (reg_addr[1:0] == 2'b00);
  assign bank_idx    = reg_addr[BIDX_W+1:2];
  assign own_hit     = aligned && in_window(reg_addr, A_OWN);
  assign stat_hit    = aligned && in_window(reg_addr, A_STAT);
  assign ena_hit     = aligned && in_window(reg_addr, A_ENA);
  assign cfg_off     = reg_addr - A_CFG;
  assign cfg_hit     = aligned && (reg_addr >= A_CFG) &&
                       (cfg_off[ADDR_W-1:3] < (ADDR_W-3)'(NUM_PINS));
  assign pin_idx     = cfg_off[PIDX_W+2:3];
  assign cfg_aux_sel = cfg_off[2];
  assign any_hit     = own_hit | stat_hit | ena_hit | cfg_hit;
  assign unused_abits = ^cfg_off[1:0];

  // ---------------- bank registers ----------------
  logic [PAD_W-1:0] own_q, ena_q, stat_vec, clr_vec;
  logic [PAD_W-1:0] wr_spread;

  always_comb begin
    wr_spread = '0;
    wr_spread[int'(bank_idx)*BANK_W +: BANK_W] = reg_wdata;
    clr_vec = (reg_wr && stat_hit) ? (wr_spread & VALID_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= PAD_W'(OWN_INIT);
      ena_q <= '0;
    end else if (reg_wr) begin
      if (own_hit) own_q[int'(bank_idx)*BANK_W +: BANK_W] <=
                     reg_wdata & VALID_MASK[int'(bank_idx)*BANK_W +: BANK_W];
      if (ena_hit) ena_q[int'(bank_idx)*BANK_W +: BANK_W] <=
                     reg_wdata & VALID_MASK[int'(bank_idx)*BANK_W +: BANK_W];
    end
  end

  // ---------------- pin cells ----------------
  logic [NUM_PINS-1:0] pin_s;
  logic [WORD_W-1:0]   main_words [NUM_PINS];
  logic [WORD_W-1:0]   aux_words  [NUM_PINS];

  gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic sel;
    assign sel = reg_wr && cfg_hit && (pin_idx == PIDX_W'(i));
    gpio_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s[i]),
      .wr_main  (sel && !cfg_aux_sel),
      .wr_aux   (sel && cfg_aux_sel),
      .wdata    (reg_wdata),
      .clr      (clr_vec[i]),
      .main_word(main_words[i]),
      .aux_word (aux_words[i]),
      .status   (stat_vec[i]),
      .pin_out  (pin_out[i]),
      .pin_oe   (pin_oe[i])
    );
  end

  for (genvar i = NUM_PINS; i < PAD_W; i++) begin : g_pad
    assign stat_vec[i] = 1'b0;
  end

  assign irq = |(stat_vec & ena_q);

  // ---------------- read path ----------------
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (own_hit)       rd_mux = own_q[int'(bank_idx)*BANK_W +: BANK_W];
    else if (stat_hit) rd_mux = stat_vec[int'(bank_idx)*BANK_W +: BANK_W];
    else if (ena_hit)  rd_mux = ena_q[int'(bank_idx)*BANK_W +: BANK_W];
    else if (cfg_hit)  rd_mux = cfg_aux_sel ? aux_words[pin_idx] : main_words[pin_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !any_hit) |=> (reg_rdata == '0));
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq);
  assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ena_q));
endmodule

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
  localparam int NP = 95;
  localparam logic [NP-1:0] OWN_PAT = {31'h5A5A_1234, 32'hDEAD_BEEF, 32'h0F0F_F0F0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic        irq;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(12), .OWN_INIT(OWN_PAT)) i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pause(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  function automatic logic [11:0] c1a(int p); return 12'(12'h100 + 8*p); endfunction
  function automatic logic [11:0] c2a(int p); return 12'(12'h104 + 8*p); endfunction
  function automatic logic [11:0] sta(int p); return 12'(12'h080 + 4*(p/32)); endfunction
  function automatic logic [11:0] ena(int p); return 12'(12'h090 + 4*(p/32)); endfunction

  task automatic stat_bit(string req, int p, logic exp);
    logic [31:0] d;
    rd(sta(p), d);
    chk(req, {31'd0, d[p%32]}, {31'd0, exp});
  endtask

  // sense on, then mode, then clear the status left by settling
  task automatic arm(int p, logic [31:0] mode_word);
    wr(c2a(p), 32'h0);
    pause(6);
    wr(c1a(p), mode_word);
    pause(6);
    wr(sta(p), 32'h1 << (p%32));
  endtask

  task automatic t_reset;
    rd_chk("R1 cfg main pin0", c1a(0), 32'h4);
    rd_chk("R1 cfg aux pin5", c2a(5), 32'h4);
    rd_chk("R1 cfg main pin94", c1a(94), 32'h4);
    for (int b = 0; b < 3; b++) begin
      rd_chk("R1 status", 12'(12'h080 + 4*b), 32'h0);
      rd_chk("R1 enable", 12'(12'h090 + 4*b), 32'h0);
    end
    rd_chk("R1 own0", 12'h000, OWN_PAT[31:0]);
    rd_chk("R1 own1", 12'h004, OWN_PAT[63:32]);
    rd_chk("R1 own2", 12'h008, {1'b0, OWN_PAT[94:64]});
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(c1a(40), 32'hFFFF_FFFF);
    rd_chk("R2 main pin40", c1a(40), 32'h8000_001F);
    rd_chk("R2 neighbour pin41", c1a(41), 32'h4);
    wr(c2a(40), 32'hFFFF_FFFF);
    rd_chk("R13 aux pin40", c2a(40), 32'h7);
    wr(c2a(40), 32'h6);
    rd_chk("R13 pull code", c2a(40), 32'h6);
    wr(c1a(40), 32'h4);
    wr(c2a(40), 32'h4);
    wr(12'h004, 32'h1234_5678);
    rd_chk("R2 own1 write", 12'h004, 32'h1234_5678);
    rd_chk("R2 own0 intact", 12'h000, OWN_PAT[31:0]);
  endtask

  task automatic t_output;
    wr(c1a(7), 32'h8000_0001);
    chk("R3 oe gpio out", {31'd0, pin_oe[7]}, 32'h1);
    chk("R3 level high", {31'd0, pin_out[7]}, 32'h1);
    chk("R3 others idle", {31'd0, pin_oe[6] | pin_oe[8]}, 32'h0);
    wr(c1a(7), 32'h0000_0001);
    chk("R3 level low", {31'd0, pin_out[7]}, 32'h0);
    chk("R3 oe kept", {31'd0, pin_oe[7]}, 32'h1);
    wr(c1a(7), 32'h8000_0000);
    chk("R3 native no drive", {31'd0, pin_oe[7]}, 32'h0);
    wr(c1a(7), 32'h8000_0005);
    chk("R3 input no drive", {31'd0, pin_oe[7]}, 32'h0);
  endtask

  task automatic t_input;
    pin_in[3] = 1'b1;
    pause(6);
    rd_chk("R4 frozen at reset", c1a(3), 32'h4);
    wr(c2a(3), 32'h0);
    pause(6);
    rd_chk("R4 follows pin", c1a(3), 32'h4000_0004);
    wr(c2a(3), 32'h4);
    pin_in[3] = 1'b0;
    pause(6);
    rd_chk("R4 held while off", c1a(3), 32'h4000_0004);
  endtask

  task automatic t_rise;
    pin_in[10] = 1'b0;
    arm(10, 32'h5);
    stat_bit("R5 clear before", 10, 1'b0);
    pin_in[10] = 1'b1; pause(6);
    stat_bit("R5 rising sets", 10, 1'b1);
    wr(sta(10), 32'h1 << 10); pause(6);
    stat_bit("R5 no re-set while high", 10, 1'b0);
    pin_in[10] = 1'b0; pause(6);
    stat_bit("R5 falling ignored", 10, 1'b0);
  endtask

  task automatic t_fall;
    pin_in[45] = 1'b1;
    arm(45, 32'hD);
    stat_bit("R6 clear before", 45, 1'b0);
    pin_in[45] = 1'b0; pause(6);
    stat_bit("R6 falling sets", 45, 1'b1);
    wr(sta(45), 32'h1 << 13);
    pin_in[45] = 1'b1; pause(6);
    stat_bit("R6 rising ignored", 45, 1'b0);
  endtask

  task automatic t_low;
    pin_in[70] = 1'b1;
    arm(70, 32'h15);
    stat_bit("R7 idle while high", 70, 1'b0);
    pin_in[70] = 1'b0; pause(6);
    stat_bit("R7 low sets", 70, 1'b1);
    wr(sta(70), 32'h1 << 6);
    stat_bit("R7 re-set while low", 70, 1'b1);
    pin_in[70] = 1'b1; pause(6);
    wr(sta(70), 32'h1 << 6); pause(2);
    stat_bit("R7 clear holds when high", 70, 1'b0);
  endtask

  task automatic t_high;
    pin_in[94] = 1'b0;
    arm(94, 32'h1D);
    stat_bit("R8 idle while low", 94, 1'b0);
    pin_in[94] = 1'b1; pause(6);
    stat_bit("R8 high sets", 94, 1'b1);
    wr(sta(94), 32'h1 << 30);
    stat_bit("R8 re-set while high", 94, 1'b1);
    pin_in[94] = 1'b0; pause(6);
    wr(sta(94), 32'h1 << 30); pause(2);
    stat_bit("R8 clear holds when low", 94, 1'b0);
  endtask

  task automatic t_nosense;
    wr(c1a(20), 32'h5);
    pin_in[20] = 1'b1; pause(6);
    stat_bit("R12 rising ignored when off", 20, 1'b0);
    wr(c1a(20), 32'h15);
    pin_in[20] = 1'b0; pause(6);
    stat_bit("R12 low ignored when off", 20, 1'b0);
  endtask

  task automatic t_w1c;
    pin_in[11] = 1'b0;
    arm(11, 32'h5);
    pin_in[10] = 1'b1; pin_in[11] = 1'b1; pause(6);
    stat_bit("R9 pin10 set", 10, 1'b1);
    stat_bit("R9 pin11 set", 11, 1'b1);
    wr(sta(10), 32'h0);
    stat_bit("R9 zero write keeps 10", 10, 1'b1);
    stat_bit("R9 zero write keeps 11", 11, 1'b1);
    wr(sta(10), 32'h1 << 10);
    stat_bit("R9 one clears 10", 10, 1'b0);
    stat_bit("R9 11 untouched", 11, 1'b1);
    wr(sta(10), 32'hFFFF_FFFF);
    rd_chk("R9 all ones clears bank", 12'h080, 32'h0);
  endtask

  task automatic t_irq;
    pin_in[10] = 1'b0; pause(6);
    pin_in[10] = 1'b1; pause(6);
    stat_bit("R10 latched without enable", 10, 1'b1);
    chk("R10 irq low when disabled", {31'd0, irq}, 32'h0);
    wr(ena(11), 32'h1 << 11);
    chk("R10 other enable no irq", {31'd0, irq}, 32'h0);
    wr(ena(10), 32'h1 << 10);
    chk("R10 irq raised", {31'd0, irq}, 32'h1);
    wr(sta(10), 32'h1 << 10);
    chk("R10 irq drops on clear", {31'd0, irq}, 32'h0);
    wr(ena(10), 32'h0);
  endtask

  task automatic t_unmapped;
    wr(12'h008, 32'hFFFF_FFFF);
    rd_chk("R11 own bank2 top bit", 12'h008, 32'h7FFF_FFFF);
    wr(12'h098, 32'hFFFF_FFFF);
    rd_chk("R11 enable bank2 top bit", 12'h098, 32'h7FFF_FFFF);
    wr(12'h098, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk("R11 gap reads 0", 12'h00C, 32'h0);
    rd_chk("R11 gap write ignored", 12'h000, OWN_PAT[31:0]);
    rd_chk("R11 above enable", 12'h0A0, 32'h0);
    wr(12'h3F8, 32'hFFFF_FFFF);
    wr(12'h3FC, 32'hFFFF_FFFF);
    rd_chk("R11 slot past pin", 12'h3F8, 32'h0);
    rd_chk("R11 pin94 main intact", c1a(94), 32'h4);
    rd_chk("R11 pin94 aux intact", c2a(94), 32'h4);
    chk("R11 irq stays low", {31'd0, irq}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    pause(3);
    rst_n = 1'b1;
    pause(2);
    t_reset;
    t_map;
    t_output;
    t_input;
    t_unmapped;
    t_rise;
    t_fall;
    t_low;
    t_high;
    t_nosense;
    t_w1c;
    t_irq;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule